// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This combinational block turns the settings of one memory-protection entry into a half-open physical byte interval `[base, limit)`. It takes three inputs: the entry's stored address word, its two-bit matching-mode field, and the stored address word of the entry just below it. The downstream access checker compares each request against the interval and does not need to know which matching mode produced it.

The stored address words hold physical address bits `ADDR_W-1:2`. This makes every bound a multiple of four bytes. The limit output is one bit wider than a physical address, so a region that runs to the very top of the address space can still be written exclusively. Two flags make the checker's job simpler. One marks a region that spans the whole address space. The other marks a region that can never match.

Locking, permission bits and the storage of the entry registers all belong to neighbouring logic. This block only decodes.

Top module: `region_bounds_dec`

## Requirements
- R1: The mode input is encoded as 0 = disabled, 1 = top-of-range, 2 = naturally aligned four-byte, 3 = naturally aligned power-of-two.
- R2: In disabled mode the outputs are base 0, limit 0, empty flag 1 and full flag 0.
- R3: In top-of-range mode, base is the lower entry's address word times four and limit is this entry's address word times four.
- R4: In top-of-range mode with `entry_first_i` = 1, base is 0 whatever the lower entry's word holds.
- R5: A top-of-range region whose limit is not greater than its base has the empty flag set.
- R6: In four-byte mode, base is the address word times four and limit is base plus 4. This includes the topmost word, where limit equals 2^ADDR_W.
- R7: In power-of-two mode, let t be the count of consecutive ones starting at bit 0 of the address word, with t below the word width. The region size is 2^(t+3) bytes. The base is the word with its lowest t bits cleared, times four.
- R8: In power-of-two mode, an address word of all ones gives base 0 and limit 2^ADDR_W.
- R9: The full flag is 1 exactly when base is 0 and limit is 2^ADDR_W.
- R10: The empty flag is 1 exactly in disabled mode, or in top-of-range mode when limit is not greater than base. Four-byte and power-of-two regions are never empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Matching mode of this entry |
| addr_word_i | input | ADDR_W-2 | This entry's stored address word (address bits ADDR_W-1:2) |
| prev_word_i | input | ADDR_W-2 | Stored address word of the entry below |
| entry_first_i | input | 1 | High when this is the lowest entry; the lower bound in top-of-range mode is then 0 |
| base_o | output | ADDR_W | Inclusive lower byte bound |
| limit_o | output | ADDR_W+1 | Exclusive upper byte bound |
| full_o | output | 1 | Region covers the whole address space |
| empty_o | output | 1 | Region matches no address |

## Verification
The bench builds the decoder with `ADDR_W` = 12, which makes the address word ten bits wide. At this width, random words reach every trailing-ones count with useful frequency. That includes the two counts (nine and ten) that stretch a power-of-two region over the whole space. It also includes the four-byte case at the last word, where the limit needs its extra bit. Directed vectors cover inverted and equal top-of-range bounds, and the first-entry override with a non-zero lower word.

// File: rtl/region_bounds_pkg.sv
package region_bounds_pkg;

  typedef enum logic [1:0] {
    RM_OFF   = 2'd0,
    RM_TOR   = 2'd1,
    RM_NA4   = 2'd2,
    RM_NAPOT = 2'd3
  } region_mode_e;

endpackage

// File: rtl/rb_trailing_ones.sv
module rb_trailing_ones #(
  parameter int W   = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word_i,
  output logic [CW-1:0] count_o
);

  logic [CW-1:0] cnt;

  // Priority encoder: the lowest zero bit wins.
  always_comb begin
    cnt = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!word_i[i]) cnt = CW'(i);
    end
  end

  assign count_o = cnt;

  always_comb begin
    if (int'(cnt) < W) begin
      // R7
      cnt_hits_zero_chk: assert (!word_i[cnt]);
    end
  end

endmodule

// File: rtl/rb_tor_range.sv
module rb_tor_range #(
  parameter int ADDR_W = 12,
  localparam int RW    = ADDR_W - 2,
  localparam int LW    = ADDR_W + 1
) (
  input  logic [RW-1:0]     word_i,
  input  logic [RW-1:0]     prev_i,
  input  logic              first_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LW-1:0]     limit_o,
  output logic              empty_o
);

  always_comb begin
    base_o  = first_i ? '0 : {prev_i, 2'b00};
    limit_o = {1'b0, word_i, 2'b00};
    empty_o = (limit_o <= {1'b0, base_o});
  end

endmodule

// File: rtl/rb_napot_range.sv
module rb_napot_range #(
  parameter int ADDR_W = 12,
  localparam int RW    = ADDR_W - 2,
  localparam int LW    = ADDR_W + 1,
  localparam int CW    = $clog2(RW + 1)
) (
  input  logic [RW-1:0]     word_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LW-1:0]     limit_o
);

  localparam logic [LW-1:0] TOP = LW'(1) << ADDR_W;

  logic [CW-1:0] ones;
  logic [RW-1:0] cleared;
  logic [LW-1:0] size;

  rb_trailing_ones #(.W(RW)) u_ones (
    .word_i  (word_i),
    .count_o (ones)
  );

  always_comb begin
    cleared = word_i & (word_i + RW'(1));
    size    = LW'(1) << (LW'(ones) + LW'(3));
    if (int'(ones) == RW) begin
      base_o  = '0;
      limit_o = TOP;
    end else begin
      base_o  = {cleared, 2'b00};
      limit_o = {1'b0, base_o} + size;
    end
  end

  always_comb begin
    // R7
    napot_aligned_chk: assert (({1'b0, base_o} & (limit_o - {1'b0, base_o} - LW'(1))) == '0);
  end

endmodule

// File: rtl/region_bounds_dec.sv
module region_bounds_dec
  import region_bounds_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int RW    = ADDR_W - 2,
  localparam int LW    = ADDR_W + 1
) (
  input  logic [1:0]        mode_i,
  input  logic [RW-1:0]     addr_word_i,
  input  logic [RW-1:0]     prev_word_i,
  input  logic              entry_first_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LW-1:0]     limit_o,
  output logic              full_o,
  output logic              empty_o
);

  localparam logic [LW-1:0] TOP = LW'(1) << ADDR_W;

  region_mode_e      mode;
  logic [ADDR_W-1:0] tor_base, nap_base, na4_base;
  logic [LW-1:0]     tor_limit, nap_limit;
  logic              tor_empty;

  assign mode     = region_mode_e'(mode_i);
  assign na4_base = {addr_word_i, 2'b00};

  rb_tor_range #(.ADDR_W(ADDR_W)) u_tor (
    .word_i  (addr_word_i),
    .prev_i  (prev_word_i),
    .first_i (entry_first_i),
    .base_o  (tor_base),
    .limit_o (tor_limit),
    .empty_o (tor_empty)
  );

  rb_napot_range #(.ADDR_W(ADDR_W)) u_napot (
    .word_i  (addr_word_i),
    .base_o  (nap_base),
    .limit_o (nap_limit)
  );

  always_comb begin
    unique case (mode)
      RM_TOR: begin
        base_o  = tor_base;
        limit_o = tor_limit;
        empty_o = tor_empty;
      end
      RM_NA4: begin
        base_o  = na4_base;
        limit_o = {1'b0, na4_base} + LW'(4);
        empty_o = 1'b0;
      end
      RM_NAPOT: begin
        base_o  = nap_base;
        limit_o = nap_limit;
        empty_o = 1'b0;
      end
      default: begin
        base_o  = '0;
        limit_o = '0;
        empty_o = 1'b1;
      end
    endcase
    full_o = (base_o == '0) && (limit_o == TOP);
  end

  always_comb begin
    // R2
    off_is_empty_chk: assert (mode != RM_OFF || (empty_o && !full_o));
    // R6
    na4_span_chk: assert (mode != RM_NA4 || (limit_o - {1'b0, base_o}) == LW'(4));
    // R10
    nonempty_order_chk: assert (empty_o || limit_o > {1'b0, base_o});
    // R9
    full_excl_empty_chk: assert (!(full_o && empty_o));
    // R8
    napot_all_ones_chk: assert (mode != RM_NAPOT || !(&addr_word_i) || full_o);
  end

endmodule

// File: tb/region_bounds_dec_tb.sv
module region_bounds_dec_tb_top;

  localparam int AW = 12;
  localparam int RW = AW - 2;

  logic          clk = 1'b0;
  logic [1:0]    mode;
  logic [RW-1:0] word, prev;
  logic          first;
  logic [AW-1:0] base;
  logic [AW:0]   limit;
  logic          full, empty;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  region_bounds_dec #(.ADDR_W(AW)) dut_i (
    .mode_i        (mode),
    .addr_word_i   (word),
    .prev_word_i   (prev),
    .entry_first_i (first),
    .base_o        (base),
    .limit_o       (limit),
    .full_o        (full),
    .empty_o       (empty)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: bounds computed with plain integers.
  task automatic apply(string req, int m, int w, int p, bit f);
    longint eb, el, top;
    bit ee, ef;
    int t;
    @(posedge clk);
    #1;
    mode = 2'(m); word = RW'(w); prev = RW'(p); first = f;
    top = longint'(1) << AW;
    ee = 0;
    case (m)
      1: begin
        eb = f ? 0 : longint'(p) * 4;
        el = longint'(w) * 4;
        ee = (el <= eb);
      end
      2: begin
        eb = longint'(w) * 4;
        el = eb + 4;
      end
      3: begin
        t = 0;
        while (t < RW && ((w >> t) & 1) == 1) t++;
        if (t == RW) begin
          eb = 0; el = top;
        end else begin
          eb = longint'((w >> t) << t) * 4;
          el = eb + (longint'(1) << (t + 3));
        end
      end
      default: begin
        eb = 0; el = 0; ee = 1;
      end
    endcase
    ef = (eb == 0) && (el == top);
    @(negedge clk);
    check(req, "base", longint'(base), eb);
    check(req, "limit", longint'(limit), el);
    check("R9", "full", longint'(full), longint'(ef));
    check("R10", "empty", longint'(empty), longint'(ee));
  endtask

  initial begin
    mode = 0; word = 0; prev = 0; first = 0;
    // reset-like idle state: disabled entry
    apply("R2", 0, 0, 0, 0);
    apply("R2", 0, 'h155, 'h2A, 1);
    // R1 encodings each selected
    apply("R1", 1, 20, 3, 0);
    apply("R1", 2, 20, 3, 0);
    apply("R1", 3, 20, 3, 0);
    // R3 ordinary top-of-range
    apply("R3", 1, 10, 4, 0);
    apply("R3", 1, 'h3FF, 0, 0);
    // R4 first entry ignores lower word
    apply("R4", 1, 10, 'h200, 1);
    apply("R4", 1, 0, 'h200, 1);
    // R5 inverted and equal bounds
    apply("R5", 1, 4, 10, 0);
    apply("R5", 1, 7, 7, 0);
    // R6 four-byte, including the last word
    apply("R6", 2, 0, 0, 0);
    apply("R6", 2, 'h3FF, 0, 0);
    // R7 power-of-two with various trailing-ones counts
    apply("R7", 3, 'h057, 0, 0);
    apply("R7", 3, 'h000, 0, 0);
    apply("R7", 3, 'h0FE, 0, 0);
    apply("R7", 3, 'h2FF, 0, 0);
    apply("R7", 3, 'h1FF, 0, 0);
    // R8 all ones spans everything
    apply("R8", 3, 'h3FF, 0, 0);
    // random sweep over every mode
    for (int i = 0; i < 400; i++) begin
      int m;
      m = i % 4;
      apply(m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R6" : "R7",
            m, int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
            bit'($urandom_range(0, 1)));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule